// File: doc/BRIEF.md
# Controller Data RAM with Embedded Return Stack

This block is the 64-byte on-chip data memory of a small 8-bit controller. One array serves three clients. A direct port reaches the eight low locations by a 3-bit register index. An indirect port uses the byte held in location 0 or location 1 as a pointer to any location. A call/return port saves and restores 10-bit program counter values in a stack that lives inside the same array.

The stack occupies locations 8 to 23. A 3-bit stack pointer selects one of eight two-byte levels, so level `n` starts at byte `8 + 2*n`. A call stores the program counter exactly as given. A return gives it back plus one. Each stack operation takes two clock cycles, one per byte. While it runs, the stack owns the array and any data access waits. Stack bytes above the current nesting depth stay ordinary memory that the indirect port can use.

Top module: `data_ram_rstack`

## Requirements
- R1: After reset, `stk_ptr` is 0 and `busy`, `ret_valid`, `rd_valid`, `ptr_err` and `acc_stall` are all low.
- R2: A direct access accepted at a clock edge uses location `reg_idx` (0 to 7). A write stores `reg_wdata` at that edge. A read returns the byte on `rd_data` with `rd_valid` high during the following cycle only.
- R3: An indirect access reads the pointer from location `ind_sel` (0 or 1) and uses its low 6 bits as the target address. Any location 0 to 63 can be reached, including the pointer locations themselves. Write and read timing are the same as R2.
- R4: When bit 7 or bit 6 of the pointer is set, the access goes to the masked address (pointer & 63). `ptr_err` is then high during the cycle after acceptance. For a valid pointer it stays low.
- R5: A call accepted while idle holds `busy` high for that cycle and the next. The call writes `pc_in[7:0]` to byte `8+2*stk_ptr` and `{6'b0, pc_in[9:8]}` to the byte after it. `stk_ptr` goes up by one at the second edge.
- R6: A return accepted while idle first lowers `stk_ptr` by one at the first edge, then reads that level. In the cycle after the second edge, `ret_valid` is high for one cycle and `ret_pc` is the stored value plus one, modulo 1024.
- R7: `stk_ptr` wraps modulo 8. A ninth nested call overwrites level 0, and a return from depth 0 reads level 7.
- R8: `acc_stall` is high whenever a data request cannot be served. This happens when a stack operation is requested or running, or when direct and indirect requests arrive together, in which case the direct one is served and the indirect one waits. A stalled request neither writes memory nor produces `rd_valid`.
- R9: Stack bytes above the current depth keep whatever the indirect port writes to them across later calls and returns that do not reach them.
- R10: When `call_req` and `ret_req` are both high in an idle cycle, the call is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_req | input | 1 | Direct access request |
| reg_we | input | 1 | Direct access is a write |
| reg_idx | input | 3 | Direct register index |
| reg_wdata | input | 8 | Direct write data |
| ind_req | input | 1 | Indirect access request |
| ind_we | input | 1 | Indirect access is a write |
| ind_sel | input | 1 | Pointer select: location 0 or 1 |
| ind_wdata | input | 8 | Indirect write data |
| call_req | input | 1 | Push request, one-cycle pulse |
| ret_req | input | 1 | Pop request, one-cycle pulse |
| pc_in | input | 10 | Program counter to save on a call |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid pulse |
| ptr_err | output | 1 | Indirect pointer had bit 7 or 6 set |
| acc_stall | output | 1 | A data request is waiting this cycle |
| busy | output | 1 | Stack operation in progress |
| stk_ptr | output | 3 | Current stack pointer |
| ret_valid | output | 1 | Return address valid pulse |
| ret_pc | output | 10 | Incremented return address |

## Verification
The indirect port is swept over every target address, writing through one pointer and reading back through the other. This separates a correct pointer fetch from a port that ignores `ind_sel` or addresses by index. Pointers with bit 6, bit 7 or both set show masking apart from error flagging. A nine-deep call chain followed by nine returns, checked against a stack model and against the raw stack bytes, catches wrong byte order, a missing increment, bad wrap and the overwrite of level 0. Last, colliding requests (call with direct write, direct with indirect, call with return) and carry cases such as 255 and 1023 test the priority rules and the width of the return increment.

// File: rtl/ramstk_pkg.sv
package ramstk_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE    = 2'd0,
      SQ_PUSH_HI = 2'd1,
      SQ_POP_HI  = 2'd2
   } sq_state_e;

endpackage

// File: rtl/ramstk_array.sv
module ramstk_array #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] ra_addr,
   output logic [DATA_W-1:0] ra_data,
   input  logic [ADDR_W-1:0] rb_addr,
   output logic [DATA_W-1:0] rb_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && (waddr == ADDR_W'(w)))
            q <= wdata;
      end
      assign words[w] = q;
   end

   assign ra_data = words[ra_addr];
   assign rb_data = words[rb_addr];
endmodule

// File: rtl/ramstk_seq.sv
module ramstk_seq
   import ramstk_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 6,
   parameter int PC_W     = 10,
   parameter int SP_W     = 3,
   parameter int STK_BASE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_req,
   input  logic              ret_req,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [DATA_W-1:0] rd_a,
   output logic              stk_we,
   output logic [ADDR_W-1:0] stk_addr,
   output logic [DATA_W-1:0] stk_wdata,
   output logic              busy,
   output logic              sq_idle,
   output logic [SP_W-1:0]   sp,
   output logic              ret_valid,
   output logic [PC_W-1:0]   ret_pc
);
   localparam int HI_W = PC_W - DATA_W;

   sq_state_e         st, st_nx;
   logic [SP_W-1:0]   sp_nx, sp_dec;
   logic [DATA_W-1:0] hold, hold_nx;
   logic [ADDR_W-1:0] lvl_addr, lvl_dec_addr;

   assign sp_dec       = sp - 1'b1;
   assign lvl_addr     = ADDR_W'(STK_BASE) + ADDR_W'({sp, 1'b0});
   assign lvl_dec_addr = ADDR_W'(STK_BASE) + ADDR_W'({sp_dec, 1'b0});

   assign sq_idle = (st == SQ_IDLE);
   assign busy    = !sq_idle || call_req || ret_req;

   always_comb begin
      st_nx     = st;
      sp_nx     = sp;
      hold_nx   = hold;
      stk_we    = 1'b0;
      stk_addr  = lvl_addr;
      stk_wdata = '0;
      unique case (st)
         SQ_IDLE: begin
            if (call_req) begin
               stk_we    = 1'b1;
               stk_addr  = lvl_addr;
               stk_wdata = pc_in[DATA_W-1:0];
               hold_nx   = DATA_W'(pc_in[PC_W-1:DATA_W]);
               st_nx     = SQ_PUSH_HI;
            end else if (ret_req) begin
               stk_addr = lvl_dec_addr;
               hold_nx  = rd_a;
               sp_nx    = sp_dec;
               st_nx    = SQ_POP_HI;
            end
         end
         SQ_PUSH_HI: begin
            stk_we    = 1'b1;
            stk_addr  = lvl_addr + 1'b1;
            stk_wdata = hold;
            sp_nx     = sp + 1'b1;
            st_nx     = SQ_IDLE;
         end
         SQ_POP_HI: begin
            stk_addr = lvl_addr + 1'b1;
            st_nx    = SQ_IDLE;
         end
         default: st_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         sp        <= '0;
         hold      <= '0;
         ret_valid <= 1'b0;
         ret_pc    <= '0;
      end else begin
         st        <= st_nx;
         sp        <= sp_nx;
         hold      <= hold_nx;
         ret_valid <= (st == SQ_POP_HI);
         if (st == SQ_POP_HI)
            ret_pc <= {rd_a[HI_W-1:0], hold} + PC_W'(1);
      end
   end
endmodule

// File: rtl/ramstk_port.sv
module ramstk_port #(
   parameter int  DATA_W    = 8,
   parameter int  ADDR_W    = 6,
   parameter int  IDX_W     = 3,
   parameter bit  PTR_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              reg_req,
   input  logic              reg_we,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              ind_req,
   input  logic              ind_we,
   input  logic              ind_sel,
   input  logic [DATA_W-1:0] ind_wdata,
   input  logic [DATA_W-1:0] ptr_word,
   input  logic [DATA_W-1:0] ra_data,
   output logic [ADDR_W-1:0] ptr_loc,
   output logic              acc_we,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [DATA_W-1:0] acc_wdata,
   output logic              acc_stall,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              ptr_err
);
   logic take_reg, take_ind, ptr_bad, rd_take;

   assign ptr_loc  = ADDR_W'(ind_sel);
   assign take_reg = reg_req && !busy;
   assign take_ind = ind_req && !busy && !reg_req;

   assign acc_stall = ((reg_req || ind_req) && busy) || (reg_req && ind_req);

   if (PTR_CHECK) begin : g_ptr_chk
      assign ptr_bad = |ptr_word[DATA_W-1:ADDR_W];
   end else begin : g_ptr_nochk
      assign ptr_bad = 1'b0;
   end

   assign acc_addr  = take_reg ? ADDR_W'(reg_idx) : ptr_word[ADDR_W-1:0];
   assign acc_we    = (take_reg && reg_we) || (take_ind && ind_we);
   assign acc_wdata = take_reg ? reg_wdata : ind_wdata;
   assign rd_take   = (take_reg && !reg_we) || (take_ind && !ind_we);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         ptr_err  <= 1'b0;
      end else begin
         rd_valid <= rd_take;
         ptr_err  <= take_ind && ptr_bad;
         if (rd_take)
            rd_data <= ra_data;
      end
   end
endmodule

// File: rtl/data_ram_rstack.sv
module data_ram_rstack #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 6,
   parameter int PC_W      = 10,
   parameter int SP_W      = 3,
   parameter int IDX_W     = 3,
   parameter int STK_BASE  = 8,
   parameter bit PTR_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_req,
   input  logic              reg_we,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              ind_req,
   input  logic              ind_we,
   input  logic              ind_sel,
   input  logic [DATA_W-1:0] ind_wdata,
   input  logic              call_req,
   input  logic              ret_req,
   input  logic [PC_W-1:0]   pc_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              ptr_err,
   output logic              acc_stall,
   output logic              busy,
   output logic [SP_W-1:0]   stk_ptr,
   output logic              ret_valid,
   output logic [PC_W-1:0]   ret_pc
);
   localparam int DEPTH   = 1 << ADDR_W;
   localparam int LEVELS  = 1 << SP_W;
   localparam int STK_TOP = STK_BASE + 2 * LEVELS;
   localparam int NREGS   = 1 << IDX_W;

   if (STK_TOP > DEPTH) begin : g_bad_depth
      $error("return stack does not fit in the array");
   end
   if (PC_W <= DATA_W || PC_W > 2 * DATA_W) begin : g_bad_pc
      $error("program counter must span more than one and at most two bytes");
   end
   if (NREGS > STK_BASE || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("register bank overlaps the stack");
   end
   if (DATA_W <= ADDR_W) begin : g_bad_ptr
      $error("pointer byte must be wider than the address");
   end

   logic              stk_we, acc_we, mem_we, sq_idle;
   logic [ADDR_W-1:0] stk_addr, acc_addr, ptr_loc, ra_addr;
   logic [DATA_W-1:0] stk_wdata, acc_wdata, mem_wdata, ra_data, ptr_word;

   assign ra_addr   = busy ? stk_addr : acc_addr;
   assign mem_we    = busy ? stk_we : acc_we;
   assign mem_wdata = busy ? stk_wdata : acc_wdata;

   ramstk_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (mem_we),
      .waddr   (ra_addr),
      .wdata   (mem_wdata),
      .ra_addr (ra_addr),
      .ra_data (ra_data),
      .rb_addr (ptr_loc),
      .rb_data (ptr_word)
   );

   ramstk_seq #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_W(PC_W),
      .SP_W(SP_W), .STK_BASE(STK_BASE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .call_req  (call_req),
      .ret_req   (ret_req),
      .pc_in     (pc_in),
      .rd_a      (ra_data),
      .stk_we    (stk_we),
      .stk_addr  (stk_addr),
      .stk_wdata (stk_wdata),
      .busy      (busy),
      .sq_idle   (sq_idle),
      .sp        (stk_ptr),
      .ret_valid (ret_valid),
      .ret_pc    (ret_pc)
   );

   ramstk_port #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PTR_CHECK(PTR_CHECK)
   ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .reg_req   (reg_req),
      .reg_we    (reg_we),
      .reg_idx   (reg_idx),
      .reg_wdata (reg_wdata),
      .ind_req   (ind_req),
      .ind_we    (ind_we),
      .ind_sel   (ind_sel),
      .ind_wdata (ind_wdata),
      .ptr_word  (ptr_word),
      .ra_data   (ra_data),
      .ptr_loc   (ptr_loc),
      .acc_we    (acc_we),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .acc_stall (acc_stall),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .ptr_err   (ptr_err)
   );
endmodule

// File: rtl/ramstk_chk.sv
module ramstk_chk #(
   parameter int SP_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            sq_idle,
   input logic            call_req,
   input logic            ret_req,
   input logic [SP_W-1:0] stk_ptr,
   input logic            ret_valid,
   input logic            acc_stall,
   input logic            reg_req,
   input logic            ind_req,
   input logic            rd_valid,
   input logic            ptr_err
);
   AST_BUSY_TWO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_idle && (call_req || ret_req)) |=> busy); // R5
   AST_SP_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_idle && call_req) |-> ##2 (stk_ptr == $past(stk_ptr, 2) + 1'b1)); // R7
   AST_SP_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_idle && ret_req && !call_req) |=> (stk_ptr == $past(stk_ptr) - 1'b1)); // R6
   AST_RET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |=> !ret_valid); // R6
   AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_stall |-> (busy || (reg_req && ind_req))); // R8
   AST_NO_READ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> !rd_valid); // R8
   AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_err |-> $past(ind_req)); // R4
endmodule

bind data_ram_rstack ramstk_chk #(.SP_W(SP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .sq_idle   (sq_idle),
   .call_req  (call_req),
   .ret_req   (ret_req),
   .stk_ptr   (stk_ptr),
   .ret_valid (ret_valid),
   .acc_stall (acc_stall),
   .reg_req   (reg_req),
   .ind_req   (ind_req),
   .rd_valid  (rd_valid),
   .ptr_err   (ptr_err)
);

// File: tb/tb_data_ram_rstack.sv
module tb_data_ram_rstack;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_req = 0, reg_we = 0, ind_req = 0, ind_we = 0, ind_sel = 0;
   logic [2:0] reg_idx = '0;
   logic [7:0] reg_wdata = '0, ind_wdata = '0;
   logic       call_req = 0, ret_req = 0;
   logic [9:0] pc_in = '0;
   logic [7:0] rd_data;
   logic       rd_valid, ptr_err, acc_stall, busy, ret_valid;
   logic [2:0] stk_ptr;
   logic [9:0] ret_pc;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [9:0] lvl [8];
   int         msp = 0;

   always #2 clk = ~clk;

   data_ram_rstack dut (.*);

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input int idx, input logic [7:0] v);
      reg_req = 1; reg_we = 1; reg_idx = 3'(idx); reg_wdata = v;
      @(negedge clk);
      reg_req = 0; reg_we = 0;
   endtask

   task automatic reg_rd(input int idx, output logic [7:0] v);
      reg_req = 1; reg_we = 0; reg_idx = 3'(idx);
      @(negedge clk);
      reg_req = 0;
      check("R2 rd_valid", int'(rd_valid), 1);
      v = rd_data;
   endtask

   task automatic ind_wr(input logic s, input logic [7:0] v);
      ind_req = 1; ind_we = 1; ind_sel = s; ind_wdata = v;
      @(negedge clk);
      ind_req = 0; ind_we = 0;
   endtask

   task automatic ind_rd(input logic s, output logic [7:0] v, output logic e);
      ind_req = 1; ind_we = 0; ind_sel = s;
      @(negedge clk);
      ind_req = 0;
      check("R3 rd_valid", int'(rd_valid), 1);
      v = rd_data;
      e = ptr_err;
   endtask

   task automatic peek(input int a, output logic [7:0] v);
      logic e;
      reg_wr(0, 8'(a));
      ind_rd(0, v, e);
   endtask

   task automatic do_call(input logic [9:0] pc);
      call_req = 1; pc_in = pc;
      #1 check("R5 busy first", int'(busy), 1);
      @(negedge clk);
      call_req = 0;
      check("R5 busy second", int'(busy), 1);
      @(negedge clk);
      check("R5 busy done", int'(busy), 0);
      lvl[msp] = pc;
      msp = (msp + 1) % 8;
      check("R7 sp after call", int'(stk_ptr), msp);
   endtask

   task automatic do_ret(output logic [9:0] pc);
      ret_req = 1;
      @(negedge clk);
      ret_req = 0;
      msp = (msp + 7) % 8;
      check("R6 sp decremented first", int'(stk_ptr), msp);
      @(negedge clk);
      check("R6 ret_valid", int'(ret_valid), 1);
      pc = ret_pc;
      @(negedge clk);
      check("R6 ret_valid single", int'(ret_valid), 0);
   endtask

   initial begin
      #800000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic       e;
      logic [9:0] rp;
      logic [9:0] pcs [9];

      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 stk_ptr", int'(stk_ptr), 0);
      check("R1 busy", int'(busy), 0);
      check("R1 ret_valid", int'(ret_valid), 0);
      check("R1 rd_valid", int'(rd_valid), 0);
      check("R1 acc_stall", int'(acc_stall), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ptr_err", int'(ptr_err), 0);

      // R2 direct sweep
      for (int i = 0; i < 8; i++) reg_wr(i, 8'(8'h3C ^ (i * 37)));
      for (int i = 0; i < 8; i++) begin
         reg_rd(i, v);
         check("R2 direct data", int'(v), int'(8'(8'h3C ^ (i * 37))));
      end

      // R3 indirect sweep: write via pointer 0, read via pointer 1
      for (int a = 2; a < 64; a++) begin
         reg_wr(0, 8'(a));
         ind_wr(0, 8'(a ^ 8'hA5));
      end
      for (int a = 2; a < 64; a++) begin
         reg_wr(1, 8'(a));
         ind_rd(1, v, e);
         check("R3 indirect data", int'(v), (a ^ 8'hA5) & 255);
         check("R4 no err on valid ptr", int'(e), 0);
      end
      for (int i = 2; i < 8; i++) begin
         reg_rd(i, v);
         check("R3 indirect reaches bank", int'(v), (i ^ 8'hA5) & 255);
      end
      reg_wr(1, 8'h77);
      reg_wr(0, 8'h01);
      ind_rd(0, v, e);
      check("R3 pointer at pointer", int'(v), 8'h77);

      // R4 out-of-range pointer is masked and flagged
      for (int h = 1; h < 4; h++) begin
         reg_wr(1, 8'((h << 6) | 20));
         ind_rd(1, v, e);
         check("R4 masked data", int'(v), (20 ^ 8'hA5) & 255);
         check("R4 ptr_err", int'(e), 1);
      end

      // R5 R7 nine nested calls
      for (int k = 0; k < 9; k++) begin
         pcs[k] = 10'((k * 113 + 5) % 1024);
         do_call(pcs[k]);
      end
      for (int k = 0; k < 8; k++) begin
         peek(8 + 2 * k, v);
         check("R5 low byte", int'(v), int'(lvl[k][7:0]));
         peek(9 + 2 * k, v);
         check("R5 high byte", int'(v), int'(lvl[k][9:8]));
      end
      check("R7 level0 overwritten", int'(lvl[0]), int'(pcs[8]));
      for (int k = 0; k < 9; k++) begin
         logic [9:0] exp;
         exp = lvl[(msp + 7) % 8] + 10'd1;
         do_ret(rp);
         check("R6 R7 return value", int'(rp), int'(exp));
      end

      // R6 carry cases
      do_call(10'd1023);
      do_ret(rp);
      check("R6 wrap 1023", int'(rp), 0);
      do_call(10'd255);
      do_ret(rp);
      check("R6 carry 255", int'(rp), 256);

      // R10 call wins over return
      call_req = 1; ret_req = 1; pc_in = 10'h2B7;
      @(negedge clk);
      call_req = 0; ret_req = 0;
      @(negedge clk);
      lvl[msp] = 10'h2B7; msp = (msp + 1) % 8;
      check("R10 sp after both", int'(stk_ptr), msp);
      do_ret(rp);
      check("R10 stored pc", int'(rp), 10'h2B8);

      // R8 call collides with direct write
      reg_wr(3, 8'h11);
      call_req = 1; pc_in = 10'h055;
      reg_req = 1; reg_we = 1; reg_idx = 3'd3; reg_wdata = 8'h5A;
      #1 check("R8 stall on call", int'(acc_stall), 1);
      @(negedge clk);
      call_req = 0;
      check("R8 stall second cycle", int'(acc_stall), 1);
      @(negedge clk);
      lvl[msp] = 10'h055; msp = (msp + 1) % 8;
      check("R8 stall released", int'(acc_stall), 0);
      @(negedge clk);
      reg_req = 0; reg_we = 0;
      reg_rd(3, v);
      check("R8 write after stall", int'(v), 8'h5A);
      do_ret(rp);
      check("R8 stack unaffected", int'(rp), 10'h056);

      // R8 direct wins over indirect
      reg_wr(0, 8'd30);
      ind_wr(0, 8'h10);
      reg_wr(2, 8'hC3);
      reg_req = 1; reg_we = 0; reg_idx = 3'd2;
      ind_req = 1; ind_we = 1; ind_sel = 0; ind_wdata = 8'h99;
      #1 check("R8 stall on clash", int'(acc_stall), 1);
      @(negedge clk);
      reg_req = 0; ind_req = 0; ind_we = 0;
      check("R8 direct served", int'(rd_data), 8'hC3);
      ind_rd(0, v, e);
      check("R8 indirect held off", int'(v), 8'h10);

      // R9 unused stack bytes are scratch
      reg_wr(0, 8'd12);
      ind_wr(0, 8'hE4);
      do_call(10'h3FF);
      do_ret(rp);
      do_call(10'h001);
      peek(12, v);
      check("R9 scratch kept", int'(v), 8'hE4);
      do_ret(rp);
      check("R9 return ok", int'(rp), 2);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule